// File: doc/BRIEF.md
# Target-Side Tagged Receive Queue with Interrupt Status

This block sits between a byte-level I2C target engine and a register interface. The engine pushes one entry for each bus event it has handled on the receive side. Each entry holds a data byte and a seven-bit tag that records the bus conditions around that byte. The register side sees the oldest entry at all times, as its byte and its tag. A pop removes that entry. Software must pop stop and repeated-start entries in the same way, even though their byte is meaningless.

For read traffic the engine reports three events: a read request that follows a start, a request for a further byte, and a cancelled read. Software answers a request by writing the transmit byte. If the engine needs that byte before software has written it, the block records a read timeout. Any byte written after the timeout is recorded as a late write and thrown away.

All events collect in a status word. A matching enable word gates them onto a single interrupt line, which feeds a shared interrupt summary.

Top module: `i2c_tgt_rxq`

## Requirements
- R1: Entries leave the queue in push order. `rxq_head_data` and `rxq_head_tag` show the oldest entry, and a pop removes it. The tag is stored without change. Its bit meanings are: bit0 byte valid for address 1, bit1 byte valid for address 2, bit2 ack/nack sent, bit3 timeout nack, bit4 first byte after a start, bit5 repeated start, bit6 stop. While the queue is empty both head outputs read zero.
- R2: A pop removes an entry whose tag carries only stop (bit6) or only repeated start (bit5), exactly as it removes a data entry.
- R3: The queue holds `DEPTH` entries (default 8). A push into a full queue is dropped unless a pop happens in the same cycle. A dropped push sets `rxq_overflow`, which stays set until a `rxq_ovf_clr` pulse. A set in the same cycle as the clear wins.
- R4: Status bit0 reports that the queue needs service. It is 1 exactly while the queue is non-empty, and a write-1 clear has no effect on it.
- R5: Status bits 1 to 5 are sticky and are set in the cycle after an event, as follows. Bit1 is write transfer complete. Bit2 is a read request after a start. Bit3 is set together with bit2 when the request followed a repeated start. Bit4 is a request for a further read byte. Bit5 is a cancelled read.
- R6: A pulse on `sts_clr_we` clears each sticky status bit whose bit is 1 in `sts_clr_mask`. If an event sets a bit in the same cycle as that bit is cleared, the bit ends up set.
- R7: `irq` equals the OR of (status AND enable), delayed by one cycle. `irq_en` is loaded by `irq_en_we`.
- R8: A transmit-byte write outside the timed-out state loads `eng_tx_byte` and raises `eng_tx_ready`. A `eng_tx_need` pulse consumes the byte and clears `eng_tx_ready`. A cancel also clears `eng_tx_ready`.
- R9: A `eng_tx_need` pulse while `eng_tx_ready` is 0 sets status bit6 (read timed out) and puts the block into the timed-out state. The next read request, further-byte request or cancel leaves that state.
- R10: A transmit-byte write in the timed-out state sets status bit7 (late write) and leaves `eng_tx_byte` and `eng_tx_ready` unchanged.
- R11: After reset the queue is empty, and status, enable, `irq`, `rxq_overflow` and `eng_tx_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_push | input | 1 | Engine pushes an entry |
| eng_data | input | 8 | Byte of pushed entry |
| eng_tag | input | 7 | Tag of pushed entry |
| eng_wr_done | input | 1 | Write transfer complete event |
| eng_rd_req | input | 1 | Read request after a start |
| eng_rd_rep | input | 1 | Qualifies eng_rd_req: it followed a repeated start |
| eng_rd_next | input | 1 | Request for a further read byte |
| eng_rd_cancel | input | 1 | Read cancelled |
| eng_tx_need | input | 1 | Engine takes the transmit byte now |
| eng_tx_byte | output | 8 | Transmit byte |
| eng_tx_ready | output | 1 | Transmit byte has been supplied |
| rxq_pop | input | 1 | Pop the head entry (data register read) |
| rxq_head_data | output | 8 | Head entry byte |
| rxq_head_tag | output | 7 | Head entry tag |
| rxq_overflow | output | 1 | Sticky overflow flag |
| rxq_ovf_clr | input | 1 | Clears the overflow flag |
| tx_wr | input | 1 | Transmit byte write |
| tx_wdata | input | 8 | Transmit byte value |
| irq_en_we | input | 1 | Enable word write |
| irq_en_wdata | input | 8 | Enable word value |
| sts_clr_we | input | 1 | Write-1-to-clear strobe |
| sts_clr_mask | input | 8 | Bits to clear |
| irq_status | output | 8 | Status word |
| irq_en | output | 8 | Enable word |
| irq | output | 1 | Interrupt line |

## Verification
Queue contents, `rxq_overflow`, status bits, `eng_tx_byte` and `eng_tx_ready` are all due one clock edge after the input that causes them. `irq` is due one edge after the status and enable values it is built from. The bench holds each input across exactly one rising edge and updates its model once for that edge. It compares outputs a nanosecond later. The model carries a one-cycle delayed interrupt term, so `irq` is compared against the status and enable of the previous cycle.

// File: rtl/tfq_pkg.sv
package tfq_pkg;
  localparam int DATA_W = 8;
  localparam int TAG_W  = 7;
  localparam int STS_W  = 8;
  // status bit positions
  localparam int ST_SVC   = 0;
  localparam int ST_WDONE = 1;
  localparam int ST_RREQ  = 2;
  localparam int ST_RREP  = 3;
  localparam int ST_RNEXT = 4;
  localparam int ST_RCAN  = 5;
  localparam int ST_RTO   = 6;
  localparam int ST_LATE  = 7;
endpackage

// File: rtl/tgt_tagq.sv
module tgt_tagq #(
  parameter int DW    = 8,
  parameter int TW    = 7,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic [TW-1:0] push_tag,
  input  logic          pop,
  input  logic          ovf_clr,
  output logic [DW-1:0] head_data,
  output logic [TW-1:0] head_tag,
  output logic          nonempty,
  output logic          ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + TW;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          pop_ok, push_ok, full;

  assign full    = (cnt_q == CW'(DEPTH));
  assign pop_ok  = pop && (cnt_q != '0);
  assign push_ok = push && (!full || pop_ok);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= {push_tag, push_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_ok) wp_q <= nxt(wp_q);
      if (pop_ok)  rp_q <= nxt(rp_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
      if (push && !push_ok) ovf_q <= 1'b1;
      else if (ovf_clr)     ovf_q <= 1'b0;
    end
  end

  logic [EW-1:0] head_w;
  assign head_w    = (cnt_q != '0) ? mem[rp_q] : '0;
  assign head_data = head_w[DW-1:0];
  assign head_tag  = head_w[EW-1:DW];
  assign nonempty  = (cnt_q != '0);
  assign ovf       = ovf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (full && ovf_q)); // R3
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R1
endmodule

// File: rtl/tgt_tx_hold.sv
module tgt_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          need,
  input  logic          rd_start,
  input  logic          cancel,
  output logic [DW-1:0] tx_byte,
  output logic          tx_ready,
  output logic          ev_tout,
  output logic          ev_late
);
  logic [DW-1:0] byte_q;
  logic          have_q, tout_q;
  logic          have_n, tout_n;

  assign ev_tout = need && !have_q;
  assign ev_late = wr && tout_q;

  always_comb begin
    have_n = have_q;
    tout_n = tout_q;
    if (need) begin
      if (!have_q) tout_n = 1'b1;
      have_n = 1'b0;
    end
    if (rd_start || cancel) tout_n = 1'b0;
    if (cancel) have_n = 1'b0;
    if (wr && !tout_q) have_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
      have_q <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      have_q <= have_n;
      tout_q <= tout_n;
      if (wr && !tout_q) byte_q <= wdata;
    end
  end

  assign tx_byte  = byte_q;
  assign tx_ready = have_q;

  AST_LATE_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (wr && tout_q) |=> $stable(byte_q)); // R10
  AST_READY_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    (wr && !tout_q) |=> have_q); // R8
endmodule

// File: rtl/tgt_irq_regs.sv
module tgt_irq_regs
  import tfq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_nonempty,
  input  logic             ev_wr_done,
  input  logic             ev_rd_req,
  input  logic             ev_rd_rep,
  input  logic             ev_rd_next,
  input  logic             ev_cancel,
  input  logic             ev_tout,
  input  logic             ev_late,
  input  logic             en_we,
  input  logic [STS_W-1:0] en_wdata,
  input  logic             clr_we,
  input  logic [STS_W-1:0] clr_mask,
  output logic [STS_W-1:0] status,
  output logic [STS_W-1:0] enable,
  output logic             irq
);
  logic [STS_W-1:1] stk_q;
  logic [STS_W-1:1] set_v, clr_v;
  logic [STS_W-1:0] en_q;
  logic             irq_q;

  always_comb begin
    set_v           = '0;
    set_v[ST_WDONE] = ev_wr_done;
    set_v[ST_RREQ]  = ev_rd_req;
    set_v[ST_RREP]  = ev_rd_req && ev_rd_rep;
    set_v[ST_RNEXT] = ev_rd_next;
    set_v[ST_RCAN]  = ev_cancel;
    set_v[ST_RTO]   = ev_tout;
    set_v[ST_LATE]  = ev_late;
    clr_v = clr_we ? clr_mask[STS_W-1:1] : '0;
  end

  assign status = {stk_q, fifo_nonempty};

  always_ff @(posedge clk) begin
    if (rst) begin
      stk_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      stk_q <= (stk_q & ~clr_v) | set_v;
      if (en_we) en_q <= en_wdata;
      irq_q <= |(status & en_q);
    end
  end

  assign enable = en_q;
  assign irq    = irq_q;

  AST_TIMEOUT_SET: assert property (@(posedge clk) disable iff (rst)
    ev_tout |=> status[ST_RTO]); // R9
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr_we && status[ST_RCAN]) |=> status[ST_RCAN]); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq); // R7
endmodule

// File: rtl/i2c_tgt_rxq.sv
module i2c_tgt_rxq
  import tfq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eng_push,
  input  logic [DATA_W-1:0] eng_data,
  input  logic [TAG_W-1:0]  eng_tag,
  input  logic              eng_wr_done,
  input  logic              eng_rd_req,
  input  logic              eng_rd_rep,
  input  logic              eng_rd_next,
  input  logic              eng_rd_cancel,
  input  logic              eng_tx_need,
  output logic [DATA_W-1:0] eng_tx_byte,
  output logic              eng_tx_ready,
  input  logic              rxq_pop,
  output logic [DATA_W-1:0] rxq_head_data,
  output logic [TAG_W-1:0]  rxq_head_tag,
  output logic              rxq_overflow,
  input  logic              rxq_ovf_clr,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              irq_en_we,
  input  logic [STS_W-1:0]  irq_en_wdata,
  input  logic              sts_clr_we,
  input  logic [STS_W-1:0]  sts_clr_mask,
  output logic [STS_W-1:0]  irq_status,
  output logic [STS_W-1:0]  irq_en,
  output logic              irq
);
  logic nonempty, ev_tout, ev_late;

  tgt_tagq #(.DW(DATA_W), .TW(TAG_W), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst(rst),
    .push(eng_push), .push_data(eng_data), .push_tag(eng_tag),
    .pop(rxq_pop), .ovf_clr(rxq_ovf_clr),
    .head_data(rxq_head_data), .head_tag(rxq_head_tag),
    .nonempty(nonempty), .ovf(rxq_overflow)
  );

  tgt_tx_hold #(.DW(DATA_W)) u_tx (
    .clk(clk), .rst(rst),
    .wr(tx_wr), .wdata(tx_wdata), .need(eng_tx_need),
    .rd_start(eng_rd_req || eng_rd_next), .cancel(eng_rd_cancel),
    .tx_byte(eng_tx_byte), .tx_ready(eng_tx_ready),
    .ev_tout(ev_tout), .ev_late(ev_late)
  );

  tgt_irq_regs u_irq (
    .clk(clk), .rst(rst),
    .fifo_nonempty(nonempty),
    .ev_wr_done(eng_wr_done), .ev_rd_req(eng_rd_req), .ev_rd_rep(eng_rd_rep),
    .ev_rd_next(eng_rd_next), .ev_cancel(eng_rd_cancel),
    .ev_tout(ev_tout), .ev_late(ev_late),
    .en_we(irq_en_we), .en_wdata(irq_en_wdata),
    .clr_we(sts_clr_we), .clr_mask(sts_clr_mask),
    .status(irq_status), .enable(irq_en), .irq(irq)
  );

  AST_SVC_EMPTY_HEAD: assert property (@(posedge clk) disable iff (rst)
    !irq_status[ST_SVC] |-> (rxq_head_data == '0 && rxq_head_tag == '0)); // R4
endmodule

// File: tb/i2c_tgt_rxq_tb_top.sv
module i2c_tgt_rxq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       push, wr_done, rd_req, rd_rep, rd_next, cancel, need, pop, ovf_clr;
  logic       txw, en_we, clr_we;
  logic [7:0] data, txd, en_d, clr_d;
  logic [6:0] tag;
  logic [7:0] tx_byte, head_data, sts, en;
  logic [6:0] head_tag;
  logic       tx_ready, ovf, irq;

  i2c_tgt_rxq dut_i (
    .clk(clk), .rst(rst), .eng_push(push), .eng_data(data), .eng_tag(tag),
    .eng_wr_done(wr_done), .eng_rd_req(rd_req), .eng_rd_rep(rd_rep),
    .eng_rd_next(rd_next), .eng_rd_cancel(cancel), .eng_tx_need(need),
    .eng_tx_byte(tx_byte), .eng_tx_ready(tx_ready), .rxq_pop(pop),
    .rxq_head_data(head_data), .rxq_head_tag(head_tag), .rxq_overflow(ovf),
    .rxq_ovf_clr(ovf_clr), .tx_wr(txw), .tx_wdata(txd), .irq_en_we(en_we),
    .irq_en_wdata(en_d), .sts_clr_we(clr_we), .sts_clr_mask(clr_d),
    .irq_status(sts), .irq_en(en), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [14:0] mq[$];
  logic [7:0]  m_stk, m_en, m_byte;
  logic        m_irq, m_ovf, m_have, m_tout;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sts();
    return {m_stk[7:1], mq.size() != 0};
  endfunction

  task automatic idle();
    push = 0; wr_done = 0; rd_req = 0; rd_rep = 0; rd_next = 0; cancel = 0;
    need = 0; pop = 0; ovf_clr = 0; txw = 0; en_we = 0; clr_we = 0;
    data = 0; tag = 0; txd = 0; en_d = 0; clr_d = 0;
  endtask

  task automatic model_reset();
    mq.delete(); m_stk = 0; m_en = 0; m_byte = 0;
    m_irq = 0; m_ovf = 0; m_have = 0; m_tout = 0;
  endtask

  // one clock edge with current inputs, then model update and compare
  task automatic step();
    logic pop_ok, push_ok, to_ev, late_ev, have_n, tout_n;
    logic [7:0] setm, clrm;
    @(posedge clk);
    #1;
    m_irq   = |(exp_sts() & m_en);
    pop_ok  = pop && mq.size() != 0;
    push_ok = push && (mq.size() < 8 || pop_ok);
    if (pop_ok) void'(mq.pop_front());
    if (push_ok) mq.push_back({tag, data});
    if (push && !push_ok) m_ovf = 1;
    else if (ovf_clr) m_ovf = 0;
    to_ev = need && !m_have;
    late_ev = txw && m_tout;
    have_n = m_have; tout_n = m_tout;
    if (need) begin if (!m_have) tout_n = 1; have_n = 0; end
    if (rd_req || rd_next || cancel) tout_n = 0;
    if (cancel) have_n = 0;
    if (txw && !m_tout) begin have_n = 1; m_byte = txd; end
    m_have = have_n; m_tout = tout_n;
    setm = {late_ev, to_ev, cancel, rd_next, rd_req & rd_rep, rd_req, wr_done, 1'b0};
    clrm = clr_we ? {clr_d[7:1], 1'b0} : 8'h0;
    m_stk = (m_stk & ~clrm) | setm;
    if (en_we) m_en = en_d;
    chk("R1 head_data", head_data, mq.size() ? 32'(mq[0][7:0]) : 0);
    chk("R1 head_tag", head_tag, mq.size() ? 32'(mq[0][14:8]) : 0);
    chk("R3 overflow", ovf, m_ovf);
    chk("R4 svc bit", sts[0], mq.size() != 0);
    chk("R5 sticky bits", sts[5:1], exp_sts() >> 1 & 5'h1f);
    chk("R9 timeout bit", sts[6], m_stk[6]);
    chk("R10 late bit", sts[7], m_stk[7]);
    chk("R7 irq", irq, m_irq);
    chk("R7 enable", en, m_en);
    chk("R8 tx_ready", tx_ready, m_have);
    chk("R8 tx_byte", tx_byte, m_byte);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int seed = 32'h5eed;
    void'($urandom(seed));
    idle(); model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R11 reset values
    chk("R11 status", sts, 0); chk("R11 enable", en, 0); chk("R11 irq", irq, 0);
    chk("R11 overflow", ovf, 0); chk("R11 tx_ready", tx_ready, 0);
    chk("R11 head_tag", head_tag, 0);
    rst = 0;
    step();
    // R3 fill beyond depth, drop, overflow
    for (int i = 0; i < 9; i++) begin
      idle(); push = 1; data = 8'(8'h10 + i); tag = 7'(i); step();
    end
    idle(); step();
    chk("R3 overflow after 9 pushes", ovf, 1);
    // R3 push+pop when full is accepted
    idle(); push = 1; pop = 1; data = 8'hAA; tag = 7'h04; step();
    chk("R3 full push with pop keeps overflow sticky", ovf, 1);
    idle(); ovf_clr = 1; step();
    chk("R3 overflow cleared", ovf, 0);
    // R2 drain, then stop-only and repstart-only entries
    idle(); pop = 1; repeat (8) step();
    chk("R2 queue empty", sts[0], 0);
    idle(); push = 1; tag = 7'h40; data = 8'h00; step();
    idle(); push = 1; tag = 7'h20; data = 8'h00; step();
    idle(); push = 1; tag = 7'h11; data = 8'h5C; step();
    idle(); pop = 1; step();
    chk("R2 stop entry removed", head_tag, 7'h20);
    step();
    chk("R2 repstart entry removed", head_data, 8'h5C);
    step();
    // R6 set wins over clear; R5 rep qualifier
    idle(); rd_req = 1; rd_rep = 1; step();
    chk("R5 rd_req with rep", sts[3:2], 2'b11);
    idle(); clr_we = 1; clr_d = 8'hFF; rd_req = 1; step();
    chk("R6 set wins over clear", sts[3:2], 2'b01);
    idle(); clr_we = 1; clr_d = 8'h01; push = 1; data = 1; step();
    chk("R4 clear of svc bit ignored", sts[0], 1);
    idle(); pop = 1; step();
    // R9 timeout then R10 late write discarded
    idle(); txw = 1; txd = 8'h3C; step();
    idle(); need = 1; step();
    chk("R8 byte consumed", tx_ready, 0);
    idle(); need = 1; step();
    chk("R9 timeout set", sts[6], 1);
    idle(); txw = 1; txd = 8'hE7; step();
    chk("R10 late write flagged", sts[7], 1);
    chk("R10 byte unchanged", tx_byte, 8'h3C);
    idle(); rd_next = 1; step();
    idle(); txw = 1; txd = 8'h81; step();
    chk("R10 write accepted after new request", tx_byte, 8'h81);
    // R7 irq enable
    idle(); en_we = 1; en_d = 8'h80; step();
    idle(); step();
    chk("R7 irq from late bit", irq, 1);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      idle();
      push = ($urandom % 2) == 0; data = 8'($urandom); tag = 7'($urandom);
      pop = ($urandom % 5) < 2;
      wr_done = ($urandom % 10) == 0; rd_req = ($urandom % 10) == 0;
      rd_rep = ($urandom % 2) == 0; rd_next = ($urandom % 10) == 0;
      cancel = ($urandom % 16) == 0; need = ($urandom % 8) == 0;
      txw = ($urandom % 8) == 0; txd = 8'($urandom);
      en_we = ($urandom % 20) == 0; en_d = 8'($urandom);
      clr_we = ($urandom % 6) == 0; clr_d = 8'($urandom);
      ovf_clr = ($urandom % 12) == 0;
      step();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule